// File: doc/BRIEF.md
# Three-Port Parallel I/O with Byte-Programmed Direction

This peripheral gives a host bus three 8-bit parallel ports, named A, B and C, plus a control location that only takes writes. One control byte sets the direction of Port A, Port B, and each 4-bit half of Port C, all at once and independently of one another. Every port bit has an output latch that the host writes. A bit drives its pin only while its port or half-port is set to output. Each bit has its own output-enable, so the surrounding pad ring can build the tri-state buffer.

Reads are combinational from the address. For an input bit, a read returns the live pin level. For an output bit, it returns the latch. After reset every port is an input and every latch holds zero. A mode-set write also returns all latches to zero, so a port that has just been turned into an output drives low until the host gives it a value.

Top module: `pario_top`

## Requirements
- R1: While reset is asserted and after it is released, every `pin_oe` bit is 0, every `pin_out` bit is 0, and every port reads back its pins.
- R2: Address 0 selects Port A (pins 7:0), address 1 selects Port B (pins 15:8), address 2 selects Port C (pins 23:16), and address 3 is the control location.
- R3: A write to address 3 with bit 7 = 1 is a mode-set. Bit 4 sets Port A, bit 1 sets Port B, bit 0 sets Port C bits 3:0, and bit 3 sets Port C bits 7:4. A 1 means input and a 0 means output. The new setting shows on `pin_oe` in the cycle after the write. Examples: 0x91 gives A input, B output, C low input, C high output. 0x9B makes everything input. 0x80 makes everything output.
- R4: A write to address 3 with bit 7 = 0 changes neither the directions nor any latch.
- R5: A mode-set write clears all three output latches to zero.
- R6: A write to a port address loads that port's latch. On each output bit, `pin_oe` is 1 and `pin_out` equals the latch from the next cycle on. On each input bit, `pin_oe` and `pin_out` are both 0.
- R7: A read of a port returns `pin_in` on its input bits and the latch on its output bits.
- R8: A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr | input | 1 | Write strobe, one per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pin_in | input | 24 | Pin levels, Port C in the top byte |
| pin_out | output | 24 | Pin drive values |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
The properties assume that `wr`, `addr` and `wdata` are sampled cleanly at each rising edge. They also assume that a mode-set and a port write never fall in the same cycle, which the single shared address guarantees. The read properties assume `pin_in` is stable while `rdata` is sampled. The bench changes all inputs one nanosecond after the rising edge and samples at the falling edge, so both conditions hold. Random traffic mixes port writes, flagged and unflagged control bytes, and pin changes. This covers every combination of directions, including the split halves of Port C.

// File: rtl/pario_pkg.sv
package pario_pkg;

  // Control-byte bit positions (the field decode depends on these)
  localparam int CB_FLAG = 7;
  localparam int CB_A    = 4;
  localparam int CB_CH   = 3;
  localparam int CB_B    = 1;
  localparam int CB_CL   = 0;

  // Register offsets
  localparam int OFF_A    = 0;
  localparam int OFF_B    = 1;
  localparam int OFF_C    = 2;
  localparam int OFF_CTRL = 3;

  // Direction of each port/half: 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cl_in;
    logic ch_in;
  } dir_cfg_t;

  localparam dir_cfg_t DIR_ALL_IN = '{a_in: 1'b1, b_in: 1'b1, cl_in: 1'b1, ch_in: 1'b1};

  function automatic dir_cfg_t pick_cfg(input logic a, input logic b,
                                        input logic cl, input logic ch);
    dir_cfg_t c;
    c.a_in  = a;
    c.b_in  = b;
    c.cl_in = cl;
    c.ch_in = ch;
    return c;
  endfunction

endpackage

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ctrl,
  input  logic     flag,
  input  dir_cfg_t cfg_in,
  output logic     mode_set,
  output dir_cfg_t cfg
);

  // Only a flagged control write is taken as a mode-set word
  assign mode_set = wr_ctrl & flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= DIR_ALL_IN;
    else if (mode_set) cfg <= cfg_in;
  end

endmodule

// File: rtl/pario_port.sv
module pario_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_port,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dir_in,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);

  logic [W-1:0] latch_q;

  // Per-bit merge: input bits from the pins, output bits from the latch
  function automatic logic [W-1:0] merge_rd(input logic [W-1:0] pins,
                                            input logic [W-1:0] lat,
                                            input logic [W-1:0] din);
    return (pins & din) | (lat & ~din);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (clr)     latch_q <= '0;
    else if (wr_port) latch_q <= wdata;
  end

  assign pin_oe  = ~dir_in;
  assign pin_out = latch_q & ~dir_in;
  assign rd_val  = merge_rd(pin_in, latch_q, dir_in);

endmodule

// File: rtl/pario_rdmux.sv
module pario_rdmux #(
  parameter int W  = 8,
  parameter int N  = 3,
  parameter int AW = 2
) (
  input  logic [AW-1:0]  addr,
  input  logic [N*W-1:0] rd_bus,
  output logic [W-1:0]   rdata
);

  always_comb begin
    rdata = '0;
    for (int p = 0; p < N; p++) begin
      if (addr == AW'(p)) rdata = rd_bus[p*W +: W];
    end
  end

endmodule

// File: rtl/pario_top.sv
module pario_top
  import pario_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    addr,
  input  logic                          wr,
  input  logic [PORT_W-1:0]             wdata,
  output logic [PORT_W-1:0]             rdata,
  input  logic [3*PORT_W-1:0]           pin_in,
  output logic [3*PORT_W-1:0]           pin_out,
  output logic [3*PORT_W-1:0]           pin_oe
);

  localparam int NUM_PORTS = 3;
  localparam int ADDR_W    = $clog2(NUM_PORTS + 1);
  localparam int HALF_W    = PORT_W / 2;
  localparam int BUS_W     = NUM_PORTS * PORT_W;

  // Named internal events for the checker
  logic     wr_ctrl;
  logic     mode_set;
  dir_cfg_t cfg;
  dir_cfg_t cfg_in;

  logic [PORT_W-1:0] dir_vec [NUM_PORTS];
  logic [BUS_W-1:0]  rd_bus;

  assign wr_ctrl = wr && (addr == ADDR_W'(OFF_CTRL));
  assign cfg_in  = pick_cfg(wdata[CB_A], wdata[CB_B], wdata[CB_CL], wdata[CB_CH]);

  pario_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .flag     (wdata[CB_FLAG]),
    .cfg_in   (cfg_in),
    .mode_set (mode_set),
    .cfg      (cfg)
  );

  always_comb begin
    dir_vec[OFF_A] = {PORT_W{cfg.a_in}};
    dir_vec[OFF_B] = {PORT_W{cfg.b_in}};
    dir_vec[OFF_C] = {{HALF_W{cfg.ch_in}}, {HALF_W{cfg.cl_in}}};
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_port;
    assign wr_port = wr && (addr == ADDR_W'(p));

    pario_port #(.W(PORT_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_port (wr_port),
      .clr     (mode_set),
      .wdata   (wdata),
      .dir_in  (dir_vec[p]),
      .pin_in  (pin_in[p*PORT_W +: PORT_W]),
      .pin_out (pin_out[p*PORT_W +: PORT_W]),
      .pin_oe  (pin_oe[p*PORT_W +: PORT_W]),
      .rd_val  (rd_bus[p*PORT_W +: PORT_W])
    );
  end

  pario_rdmux #(.W(PORT_W), .N(NUM_PORTS), .AW(ADDR_W)) u_rdmux (
    .addr   (addr),
    .rd_bus (rd_bus),
    .rdata  (rdata)
  );

endmodule

// File: rtl/pario_sva.sv
module pario_sva #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     addr,
  input logic           wr,
  input logic [W-1:0]   wdata,
  input logic [W-1:0]   rdata,
  input logic [3*W-1:0] pin_in,
  input logic [3*W-1:0] pin_out,
  input logic [3*W-1:0] pin_oe,
  input logic           mode_set
);

  AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0)); // R1

  AST_MODESET_DIR_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && wdata[7]) |=> (pin_oe[W-1:0] == {W{~$past(wdata[4])}})); // R3

  AST_UNFLAGGED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && !wdata[7]) |=> ($stable(pin_oe) && $stable(pin_out))); // R4

  AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (pin_out == '0)); // R5

  AST_PORT_A_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && pin_oe[W-1:0] == '1) |=> (pin_out[W-1:0] == $past(wdata))); // R6

  AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)); // R6

  AST_READ_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata == ((pin_in[W-1:0] & ~pin_oe[W-1:0]) |
                                  (pin_out[W-1:0] & pin_oe[W-1:0])))); // R7

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata == '0)); // R8

endmodule

bind pario_top pario_sva #(.W(PORT_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr       (wr),
  .wdata    (wdata),
  .rdata    (rdata),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .mode_set (mode_set)
);

// File: tb/tb_pario_top.sv
module tb_pario_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr;
  logic [7:0]  wdata;
  logic [23:0] pin_in;
  wire  [7:0]  rdata;
  wire  [23:0] pin_out;
  wire  [23:0] pin_oe;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  pario_top dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr      (wr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  // Behavioural reference: four direction flags (1 = input) and three latches
  bit         m_a, m_b, m_cl, m_ch;
  logic [7:0] m_lat [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 1; m_b = 1; m_cl = 1; m_ch = 1;
      for (int i = 0; i < 3; i++) m_lat[i] = 8'h00;
    end else if (wr) begin
      if (addr == 2'd3) begin
        if (wdata[7]) begin
          m_a = wdata[4]; m_b = wdata[1]; m_cl = wdata[0]; m_ch = wdata[3];
          for (int i = 0; i < 3; i++) m_lat[i] = 8'h00;
        end
      end else begin
        m_lat[addr] = wdata;
      end
    end
  end

  function automatic logic [23:0] exp_oe();
    return {{4{~m_ch}}, {4{~m_cl}}, {8{~m_b}}, {8{~m_a}}};
  endfunction

  function automatic logic [23:0] exp_out();
    return {m_lat[2], m_lat[1], m_lat[0]} & exp_oe();
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [23:0] merged;
    merged = (pin_in & ~exp_oe()) | ({m_lat[2], m_lat[1], m_lat[0]} & exp_oe());
    case (addr)
      2'd0:    return merged[7:0];
      2'd1:    return merged[15:8];
      2'd2:    return merged[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(pin_oe  === exp_oe(),  "R3 pin_oe",  pin_oe,  exp_oe());
      chk(pin_out === exp_out(), "R6 pin_out", pin_out, exp_out());
      if (addr == 2'd3)
        chk(rdata === 8'h00, "R8 rdata", {16'h0, rdata}, 24'h0);
      else
        chk(rdata === exp_rd(), "R7 rdata", {16'h0, rdata}, {16'h0, exp_rd()});
    end
  end

  task automatic wr_op(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic set_addr(input logic [1:0] a);
    @(posedge clk); #1;
    addr = a;
  endtask

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'h00; pin_in = 24'hC35A96;
    repeat (3) @(negedge clk);
    chk(pin_oe  === 24'h0, "R1 oe in reset",  pin_oe,  24'h0);
    chk(pin_out === 24'h0, "R1 out in reset", pin_out, 24'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(pin_oe === 24'h0, "R1 oe after reset", pin_oe, 24'h0);

    // R2: offset decode with all ports as inputs
    set_addr(2'd0); @(negedge clk); chk(rdata === 8'h96, "R2 addr0", {16'h0, rdata}, 24'h96);
    set_addr(2'd1); @(negedge clk); chk(rdata === 8'h5A, "R2 addr1", {16'h0, rdata}, 24'h5A);
    set_addr(2'd2); @(negedge clk); chk(rdata === 8'hC3, "R2 addr2", {16'h0, rdata}, 24'hC3);

    // R3: example control bytes
    wr_op(2'd3, 8'h91); @(negedge clk);
    chk(pin_oe === 24'hF0FF00, "R3 0x91", pin_oe, 24'hF0FF00);
    wr_op(2'd3, 8'h80); @(negedge clk);
    chk(pin_oe === 24'hFFFFFF, "R3 0x80", pin_oe, 24'hFFFFFF);
    wr_op(2'd3, 8'h9B); @(negedge clk);
    chk(pin_oe === 24'h000000, "R3 0x9B", pin_oe, 24'h000000);

    // R4: unflagged control byte changes nothing
    wr_op(2'd3, 8'h80);
    wr_op(2'd0, 8'h3C);
    wr_op(2'd3, 8'h1B); @(negedge clk);
    chk(pin_oe === 24'hFFFFFF, "R4 dir kept", pin_oe, 24'hFFFFFF);
    chk(pin_out[7:0] === 8'h3C, "R4 latch kept", {16'h0, pin_out[7:0]}, 24'h3C);

    // R5: mode-set clears latches
    wr_op(2'd1, 8'h77);
    wr_op(2'd3, 8'h80); @(negedge clk);
    chk(pin_out === 24'h0, "R5 cleared", pin_out, 24'h0);

    // R6 / R7: split Port C
    wr_op(2'd3, 8'h91);
    pin_in = 24'h3C0000;
    wr_op(2'd2, 8'hA5); @(negedge clk);
    chk(pin_out[23:16] === 8'hA0, "R6 C high drives", {16'h0, pin_out[23:16]}, 24'hA0);
    set_addr(2'd2); @(negedge clk);
    chk(rdata === 8'hAC, "R7 C merged", {16'h0, rdata}, 24'hAC);

    // R8
    set_addr(2'd3); @(negedge clk);
    chk(rdata === 8'h00, "R8 ctrl read", {16'h0, rdata}, 24'h0);

    // Random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      addr   = 2'($urandom_range(0, 3));
      wr     = 1'($urandom_range(0, 1));
      wdata  = 8'($urandom);
      if ($urandom_range(0, 3) == 0) pin_in = 24'($urandom);
    end
    @(posedge clk); #1 wr = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule